// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters on a single serial line. Software writes a character into a one-entry holding buffer. When the shift stage is free and the transmitter is active, the buffer contents move into the shift stage. Software can then write the next character while the current one is still going out. Each frame has a low start bit, then 5 to 9 data bits sent least significant bit first, then one high stop bit. Every bit lasts a fixed number of pulses of an external bit-rate tick input, 16 by default.

A small set of write strobes sets up the block:
- A control write carries the enable, the high bit of the size code, the ninth data bit and two interrupt enables.
- A format write carries the two low bits of the size code.
- A data write carries the low eight data bits.
- A clear strobe acknowledges transmit-complete.

Two flags, buffer-empty and transmit-complete, are each combined with their own enable and a global interrupt enable to form two interrupt outputs. When software clears the enable, the transmitter keeps running until every queued character has been sent. Only then does it release the line.

Top module: `usart_tx_top`

## Requirements
- R1: After reset, tx_pin is 1, tx_oe is 0, dre_flag is 1, txc_flag is 0 and both interrupt outputs are 0.
- R2: A frame is one start bit of 0, then the data bits least significant first, then one stop bit of 1. Each bit lasts OVERSAMPLE bit_tick pulses, and the line is 1 between frames.
- R3: The size code is {ctl_size_hi, fmt_size_lo}. 000 selects 5 data bits, 001 selects 6, 010 selects 7, 011 selects 8 and 111 selects 9. The codes 100, 101 and 110 select 8. fmt_size_lo resets to 11.
- R4: The ninth data bit is the ctl_bit8 value held when data_we is strobed. A later change of ctl_bit8 does not alter a character that is already queued.
- R5: dre_flag goes to 0 in the cycle after a data write. It returns to 1 when the buffer contents move into the shift stage.
- R6: txc_flag goes to 1 when a stop bit ends with the buffer empty. It stays 0 when the buffer holds a waiting character at that moment, and a txc_clr strobe returns it to 0.
- R7: txc_irq is 1 only when the transmit-complete enable, gie and txc_flag are all 1. dre_irq is 1 only when the buffer-empty enable, gie and dre_flag are all 1.
- R8: Clearing the enable takes effect only once the buffer and the shift stage both hold nothing. Characters queued before the disable are sent in full.
- R9: While the transmitter is active, tx_oe is 1. Once it is inactive, tx_oe is 0 and tx_pin stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control fields |
| ctl_en | input | 1 | Transmitter enable request |
| ctl_size_hi | input | 1 | High bit of the size code |
| ctl_bit8 | input | 1 | Ninth data bit for the next data write |
| ctl_txc_ie | input | 1 | Transmit-complete interrupt enable |
| ctl_dre_ie | input | 1 | Buffer-empty interrupt enable |
| fmt_we | input | 1 | Write strobe for the low size bits |
| fmt_size_lo | input | 2 | Low two bits of the size code |
| data_we | input | 1 | Data write strobe; queues a character |
| data_in | input | 8 | Low eight data bits |
| txc_clr | input | 1 | Write-one clear of txc_flag |
| gie | input | 1 | Global interrupt enable |
| bit_tick | input | 1 | Bit-rate tick, one cycle wide |
| tx_pin | output | 1 | Serial output line |
| tx_oe | output | 1 | Line output enable (transmitter owns the pin) |
| dre_flag | output | 1 | Buffer-empty flag |
| txc_flag | output | 1 | Transmit-complete flag |
| dre_irq | output | 1 | Buffer-empty interrupt |
| txc_irq | output | 1 | Transmit-complete interrupt |

## Verification
The bench builds the block with the default OVERSAMPLE of 16 and pulses bit_tick every second clock. Each bit therefore spans 32 clocks, and a bench monitor can sample every bit at its centre. It walks through all eight size codes, including the reserved ones that select 8 bits, and through nine-bit characters whose ninth bit is changed after queuing. Two back-to-back characters exercise the path where the buffer is refilled while a frame is shifting, which is where transmit-complete must stay low. A disable issued with two characters still queued shows that both frames are sent in full before the pin is released.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = MAX_DATA + 2;

    typedef struct packed {
        logic       b8;
        logic [7:0] lo;
    } tx_word_t;

    typedef struct packed {
        logic en;
        logic size_hi;
        logic bit8;
        logic txc_ie;
        logic dre_ie;
    } tx_ctl_t;

    function automatic logic [3:0] data_bits(input logic hi, input logic [1:0] lo);
        case ({hi, lo})
            3'b000:  data_bits = 4'd5;
            3'b001:  data_bits = 4'd6;
            3'b010:  data_bits = 4'd7;
            3'b111:  data_bits = 4'd9;
            default: data_bits = 4'd8;
        endcase
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input tx_word_t w, input logic [3:0] n);
        logic [FRAME_W-1:0] f;
        logic [MAX_DATA-1:0] d;
        d    = {w.b8, w.lo};
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(n)) f[i+1] = d[i];
        end
        return f;
    endfunction

endpackage

// File: rtl/usart_tx_hold.sv
module usart_tx_hold
    import usart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  tx_word_t wdata,
    input  logic     take,
    output logic     full,
    output tx_word_t word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr) begin
            full <= 1'b1;
            word <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/usart_tx_shifter.sv
module usart_tx_shifter
    import usart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [3:0]         nbits,
    input  logic               tick,
    output logic               busy,
    output logic               line,
    output logic               done
);
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] TK_LAST = CNT_W'(OVERSAMPLE - 1);

    logic [FRAME_W-1:0] sh;
    logic [3:0]         left;
    logic [CNT_W-1:0]   tk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
            tk   <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh   <= frame;
                left <= nbits;
                tk   <= '0;
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (tk == TK_LAST) begin
                    tk <= '0;
                    sh <= {1'b1, sh[FRAME_W-1:1]};
                    if (left == 4'd1) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left <= left - 4'd1;
                    end
                end else begin
                    tk <= tk + 1'b1;
                end
            end
        end
    end

    assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/usart_tx_flags.sv
module usart_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic buf_full,
    input  logic txc_clr,
    input  logic txc_ie,
    input  logic dre_ie,
    input  logic gie,
    output logic txc_flag,
    output logic dre_flag,
    output logic txc_irq,
    output logic dre_irq
);
    always_ff @(posedge clk) begin
        if (rst)                     txc_flag <= 1'b0;
        else if (done && !buf_full)  txc_flag <= 1'b1;
        else if (txc_clr)            txc_flag <= 1'b0;
    end

    assign dre_flag = !buf_full;
    assign txc_irq  = txc_ie & gie & txc_flag;
    assign dre_irq  = dre_ie & gie & dre_flag;
endmodule

// File: rtl/usart_tx_top.sv
module usart_tx_top
    import usart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic       ctl_en,
    input  logic       ctl_size_hi,
    input  logic       ctl_bit8,
    input  logic       ctl_txc_ie,
    input  logic       ctl_dre_ie,
    input  logic       fmt_we,
    input  logic [1:0] fmt_size_lo,
    input  logic       data_we,
    input  logic [7:0] data_in,
    input  logic       txc_clr,
    input  logic       gie,
    input  logic       bit_tick,
    output logic       tx_pin,
    output logic       tx_oe,
    output logic       dre_flag,
    output logic       txc_flag,
    output logic       dre_irq,
    output logic       txc_irq
);
    tx_ctl_t    ctl;
    logic [1:0] size_lo;
    logic       active;
    logic       buf_full;
    tx_word_t   buf_word;
    logic       sh_busy;
    logic       sh_line;
    logic       sh_done;
    logic       load;
    logic [3:0] ndata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            size_lo <= 2'b11;
        end else begin
            if (ctl_we)
                ctl <= '{en: ctl_en, size_hi: ctl_size_hi, bit8: ctl_bit8,
                         txc_ie: ctl_txc_ie, dre_ie: ctl_dre_ie};
            if (fmt_we)
                size_lo <= fmt_size_lo;
        end
    end

    // Deferred disable: drop only when nothing is queued or shifting
    always_ff @(posedge clk) begin
        if (rst)                        active <= 1'b0;
        else if (ctl.en)                active <= 1'b1;
        else if (!buf_full && !sh_busy) active <= 1'b0;
    end

    assign ndata = data_bits(ctl.size_hi, size_lo);
    assign load  = buf_full && !sh_busy && active;

    usart_tx_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .wr    (data_we),
        .wdata ('{b8: ctl.bit8, lo: data_in}),
        .take  (load),
        .full  (buf_full),
        .word  (buf_word)
    );

    usart_tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .frame (build_frame(buf_word, ndata)),
        .nbits (ndata + 4'd2),
        .tick  (bit_tick),
        .busy  (sh_busy),
        .line  (sh_line),
        .done  (sh_done)
    );

    usart_tx_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .done     (sh_done),
        .buf_full (buf_full),
        .txc_clr  (txc_clr),
        .txc_ie   (ctl.txc_ie),
        .dre_ie   (ctl.dre_ie),
        .gie      (gie),
        .txc_flag (txc_flag),
        .dre_flag (dre_flag),
        .txc_irq  (txc_irq),
        .dre_irq  (dre_irq)
    );

    assign tx_oe  = active;
    assign tx_pin = active ? sh_line : 1'b1;
endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
    input logic clk,
    input logic rst,
    input logic data_we,
    input logic gie,
    input logic tx_pin,
    input logic tx_oe,
    input logic dre_flag,
    input logic txc_flag,
    input logic dre_irq,
    input logic txc_irq,
    input logic sh_busy
);
    // R5
    dre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !dre_flag);

    // R6
    txc_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(txc_flag) |-> dre_flag);

    // R7
    txc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        txc_irq |-> (gie && txc_flag));

    // R7
    dre_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dre_irq |-> (gie && dre_flag));

    // R8
    hold_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && (sh_busy || !dre_flag)) |=> tx_oe);

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> tx_pin);
endmodule

bind usart_tx_top usart_tx_chk u_chk (.*);

// File: tb/tb_usart_tx_top.sv
module tb_usart_tx_top;
    localparam int OVS  = 16;
    localparam int TDIV = 2;
    localparam int BIT  = OVS * TDIV;

    typedef struct {
        logic [8:0] d;
        int         n;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 0, ctl_en = 0, ctl_size_hi = 0, ctl_bit8 = 0, ctl_txc_ie = 0, ctl_dre_ie = 0;
    logic       fmt_we = 0;
    logic [1:0] fmt_size_lo = 2'b00;
    logic       data_we = 0;
    logic [7:0] data_in = 8'h00;
    logic       txc_clr = 0, gie = 0, bit_tick = 0;
    logic       tx_pin, tx_oe, dre_flag, txc_flag, dre_irq, txc_irq;

    int   checks = 0, errors = 0, frames_seen = 0;
    bit   finished = 0;
    exp_t q[$];
    logic cur_hi = 0, cur_b8 = 0;
    logic [1:0] cur_lo = 2'b11;

    always #10 clk = ~clk;

    usart_tx_top #(.OVERSAMPLE(OVS)) dut (.*);

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % TDIV;
            bit_tick = (c == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int exp_bits(input logic hi, input logic [1:0] lo);
        if (!hi && lo == 2'b00) return 5;
        if (!hi && lo == 2'b01) return 6;
        if (!hi && lo == 2'b10) return 7;
        if (hi && lo == 2'b11) return 9;
        return 8;
    endfunction

    task automatic wr_ctl(input logic en, input logic hi, input logic b8, input logic tie, input logic die);
        @(negedge clk);
        ctl_we = 1; ctl_en = en; ctl_size_hi = hi; ctl_bit8 = b8; ctl_txc_ie = tie; ctl_dre_ie = die;
        cur_hi = hi; cur_b8 = b8;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic wr_fmt(input logic [1:0] lo);
        @(negedge clk);
        fmt_we = 1; fmt_size_lo = lo; cur_lo = lo;
        @(negedge clk);
        fmt_we = 0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        data_we = 1; data_in = d;
        e.d = {cur_b8, d};
        e.n = exp_bits(cur_hi, cur_lo);
        q.push_back(e);
        @(negedge clk);
        data_we = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        txc_clr = 1;
        @(negedge clk);
        txc_clr = 0;
    endtask

    task automatic wait_frames(input int k);
        while (frames_seen < k) @(negedge clk);
        repeat (BIT) @(negedge clk);
    endtask

    // Monitor: decodes frames at bit centres and compares against the queue (R2)
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && !tx_pin) begin
                exp_t e;
                logic [8:0] got = '0;
                logic [8:0] want = '0;
                logic st, sp;
                if (q.size() == 0) begin
                    e.d = '0; e.n = 8;
                    check(0, "R2 unexpected frame", 0, 1);
                end else begin
                    e = q.pop_front();
                end
                repeat (BIT/2 - 1) @(negedge clk);
                st = tx_pin;
                for (int i = 0; i < e.n; i++) begin
                    repeat (BIT) @(negedge clk);
                    got[i]  = tx_pin;
                    want[i] = e.d[i];
                end
                repeat (BIT) @(negedge clk);
                sp = tx_pin;
                check(st == 0 && sp == 1 && got == want, "R2/R3/R4 frame",
                      {st, sp, got}, {1'b0, 1'b1, want});
                frames_seen++;
            end
            prev = tx_pin;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames_seen, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(tx_pin == 1 && tx_oe == 0 && dre_flag == 1 && txc_flag == 0 && dre_irq == 0 && txc_irq == 0,
              "R1 reset", {tx_pin, tx_oe, dre_flag, txc_flag, dre_irq, txc_irq}, 6'b101000);

        wr_ctl(1, 0, 0, 1, 1);
        @(negedge clk);
        check(tx_oe == 1, "R9 oe on enable", tx_oe, 1);
        check(dre_irq == 0, "R7 dre_irq gated by gie", dre_irq, 0);
        gie = 1;
        @(negedge clk);
        check(dre_irq == 1, "R7 dre_irq with gie", dre_irq, 1);

        // R3 default 8-bit, R5 flag behaviour
        @(negedge clk);
        data_we = 1; data_in = 8'hA5;
        q.push_back('{d: 9'h0A5, n: 8});
        @(negedge clk);
        data_we = 0;
        check(dre_flag == 0, "R5 dre clears on write", dre_flag, 0);
        repeat (3) @(negedge clk);
        check(dre_flag == 1, "R5 dre sets on move", dre_flag, 1);
        wait_frames(1);
        check(txc_flag == 1, "R6 txc set after frame", txc_flag, 1);
        check(txc_irq == 1, "R7 txc_irq", txc_irq, 1);
        pulse_clr();
        check(txc_flag == 0 && txc_irq == 0, "R6 txc clear", {txc_flag, txc_irq}, 0);

        // R3 all size codes
        base = frames_seen;
        for (int s = 0; s < 8; s++) begin
            wr_ctl(1, s[2], 1, 1, 1);
            wr_fmt(s[1:0]);
            send(8'h96 ^ 8'(s * 37));
            wait_frames(base + s + 1);
        end

        // R4 ninth bit latched at data write
        wr_ctl(1, 1, 1, 1, 1);
        wr_fmt(2'b11);
        send(8'h55);
        wr_ctl(1, 1, 0, 1, 1);
        send(8'hFF);
        wait_frames(base + 10);

        // R6 no txc while a character waits
        wr_ctl(1, 0, 0, 1, 1);
        pulse_clr();
        send(8'h01);
        repeat (3) @(negedge clk);
        send(8'h80);
        while (dre_flag == 0) @(negedge clk);
        @(negedge clk);
        check(txc_flag == 0, "R6 txc held while buffer waits", txc_flag, 0);
        wait_frames(base + 12);
        check(txc_flag == 1, "R6 txc after last frame", txc_flag, 1);

        // R8 deferred disable with two characters pending
        pulse_clr();
        send(8'hC3);
        repeat (3) @(negedge clk);
        send(8'h3C);
        wr_ctl(0, 0, 0, 1, 1);
        repeat (4) @(negedge clk);
        check(tx_oe == 1, "R8 oe held after disable", tx_oe, 1);
        while (dre_flag == 0) @(negedge clk);
        check(tx_oe == 1, "R8 oe held for second frame", tx_oe, 1);
        wait_frames(base + 14);
        check(frames_seen == base + 14 && q.size() == 0, "R8 both frames sent", frames_seen, base + 14);
        repeat (4) @(negedge clk);
        // R9
        check(tx_oe == 0 && tx_pin == 1, "R9 released", {tx_oe, tx_pin}, 2'b01);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule